// File: doc/BRIEF.md
# Floating-Point Register Store Executor

This block carries out one kind of instruction: storing a single floating-point register to memory. It takes a 32-bit instruction word and decodes it. It returns the index of the floating-point register to read, and the index of the base integer register. It forms a byte address from the base value and a scaled 8-bit offset, and writes the data through a word-wide memory port with a valid/ready handshake and byte enables. Half, single and double widths are supported. A double is written as two 32-bit beats, and their order follows an endianness input.

Two inputs stand in for the checks that surround the block. `cond_ok` replaces condition-code evaluation, and `fp_on` replaces the enable and trap checks. Encodings that are not legal raise a one-cycle `undef` flag together with `done`, and no memory write is made. One instruction is taken at a time. While `busy` is high, new instructions are ignored.

Top module: `fpst_exec`

## Requirements
- R1: The instruction is undefined when any of the following holds: bits 27:24 are not 1101, bits 21:20 are not 00, bits 11:10 are not 10, the condition field in bits 31:28 is 1111, the size field in bits 9:8 is 00, or `fp_on` is low. An undefined instruction makes no memory write. It raises `done` and `undef` together for one cycle, in the cycle after acceptance, whatever the value of `cond_ok`.
- R2: A half-precision store (size 01) is undefined when `half_ok` is low. It is also undefined when its condition field is not 1110. This is the default setting, `HALF_COND_MODE`=0.
- R3: A legal instruction accepted with `cond_ok` low makes no memory write. It pulses `done` with `undef` low in the cycle after acceptance.
- R4: The byte offset is imm8 (bits 7:0) shifted left by 1 for size 01, and shifted left by 2 for sizes 10 and 11. The U bit (bit 23) equal to 1 adds the offset to `base_val`, and 0 subtracts it, both modulo 2^AW. The result is the address of the first beat.
- R5: `rf_idx` shows {Vd,D} for sizes 01 and 10, and {D,Vd} for size 11, where Vd is bits 15:12 and D is bit 22. `rf_dbl` is high only for size 11. `base_idx` shows bits 19:16. All of these are combinational from `instr_word`.
- R6: A half store writes one beat carrying `rf_rdata[15:0]`. When address bit 1 is 0, the data sits in lane bits 15:0 with `mw_be`=0011. When address bit 1 is 1, it sits in bits 31:16 with `mw_be`=1100. The unused lane is zero.
- R7: A single store writes one beat of `rf_rdata[31:0]` with `mw_be`=1111.
- R8: A double store writes two beats, both with `mw_be`=1111. The second beat goes to the first address plus 4. With `big_end` low, the first beat carries `rf_rdata[31:0]` and the second carries bits 63:32. With `big_end` high, the halves are swapped.
- R9: While `mw_valid` is high and `mw_ready` is low, address, data and enables stay unchanged. The second beat of a double appears only after the first beat is accepted.
- R10: `busy` is high from the cycle after acceptance until the final beat is accepted. An instruction is accepted only while `busy` is low, and words offered while `busy` is high are ignored. `done` pulses for one cycle after the final beat is accepted, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Instruction word |
| cond_ok | input | 1 | Condition check passed |
| fp_on | input | 1 | Floating-point unit usable |
| half_ok | input | 1 | Half-precision support present |
| big_end | input | 1 | Big-endian data order |
| base_idx | output | 4 | Base integer register index |
| base_val | input | AW | Base register value |
| rf_idx | output | 5 | Floating-point register index |
| rf_dbl | output | 1 | Read selects a 64-bit register |
| rf_rdata | input | 64 | Register read data (single in low 32 bits) |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory accepts the beat |
| mw_addr | output | AW | Byte address of the beat |
| mw_data | output | 32 | Write data |
| mw_be | output | 4 | Byte enables |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| undef | output | 1 | Finished instruction was undefined |

## Verification
The register and base indices are combinational, so they are checked one time unit after the word is applied, in the acceptance cycle. `done` and `undef` for a store that makes no write are due one cycle after acceptance, and the first write beat appears in that same cycle. The bench therefore starts its observation loop at the next falling edge. After that, each beat is compared at every falling edge on which `mw_valid` is high, and a beat counts as accepted only when the bench itself drove `mw_ready` high before the next rising edge. `done` is expected at the falling edge just after the final accepted beat, with exactly the predicted number of beats seen.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } fpst_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_B1   = 2'b01,
    ST_B2   = 2'b10
  } fpst_state_e;

  typedef struct packed {
    logic       undef;
    logic       nop;
    fpst_size_e size;
    logic       add;
    logic [7:0] imm;
    logic [4:0] ridx;
    logic [3:0] bidx;
  } fpst_dec_t;

  localparam logic [3:0] COND_AL = 4'hE;
  localparam logic [3:0] COND_NV = 4'hF;
endpackage

// File: rtl/fpst_decode.sv
module fpst_decode
  import fpst_pkg::*;
#(
  parameter int HALF_COND_MODE = 0
) (
  input  logic [31:0] iw,
  input  logic        fp_on,
  input  logic        half_ok,
  output fpst_dec_t   dec
);
  logic [3:0] cond;
  logic       d_bit;
  logic [3:0] vd;
  logic       shape_ok;
  logic       half_nal;
  logic       half_undef;
  logic       half_nop;
  fpst_size_e sz;

  always_comb begin
    cond     = iw[31:28];
    d_bit    = iw[22];
    vd       = iw[15:12];
    sz       = fpst_size_e'(iw[9:8]);
    shape_ok = (iw[27:24] == 4'b1101) && (iw[21:20] == 2'b00) && (iw[11:10] == 2'b10);
    half_nal = (sz == SZ_HALF) && (cond != COND_AL);
  end

  generate
    if (HALF_COND_MODE == 0) begin : g_half_undef
      assign half_undef = half_nal;
      assign half_nop   = 1'b0;
    end else if (HALF_COND_MODE == 1) begin : g_half_exec
      assign half_undef = 1'b0;
      assign half_nop   = 1'b0;
    end else begin : g_half_nop
      assign half_undef = 1'b0;
      assign half_nop   = half_nal;
    end
  endgenerate

  always_comb begin
    dec.size  = sz;
    dec.add   = iw[23];
    dec.imm   = iw[7:0];
    dec.bidx  = iw[19:16];
    dec.ridx  = (sz == SZ_DBL) ? {d_bit, vd} : {vd, d_bit};
    dec.undef = !fp_on || !shape_ok || (cond == COND_NV) || (sz == SZ_NONE) ||
                ((sz == SZ_HALF) && !half_ok) || half_undef;
    dec.nop   = half_nop;
  end
endmodule

// File: rtl/fpst_agen.sv
module fpst_agen
  import fpst_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  fpst_size_e    size,
  input  logic          add,
  input  logic [7:0]    imm,
  output logic [AW-1:0] addr
);
  localparam int PADH = AW - 9;
  localparam int PADW = AW - 10;

  logic [AW-1:0] off;

  always_comb begin
    if (size == SZ_HALF) off = {{PADH{1'b0}}, imm, 1'b0};
    else                 off = {{PADW{1'b0}}, imm, 2'b00};
    addr = add ? (base + off) : (base - off);
  end
endmodule

// File: rtl/fpst_seq.sv
module fpst_seq
  import fpst_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_write,
  input  logic          go_skip,
  input  logic          undef_in,
  input  fpst_size_e    size,
  input  logic [AW-1:0] addr_in,
  input  logic [63:0]   rdata,
  input  logic          big_end,
  input  logic          mw_ready,
  output logic          mw_valid,
  output logic [AW-1:0] mw_addr,
  output logic [31:0]   mw_data,
  output logic [3:0]    mw_be,
  output logic          busy,
  output logic          done,
  output logic          undef_o
);
  fpst_state_e st;
  logic        dbl_q;
  logic [31:0] hi_q;
  logic [31:0] first_w;
  logic [31:0] second_w;
  logic [3:0]  first_be;

  always_comb begin
    second_w = 32'h0;
    case (size)
      SZ_HALF: begin
        first_w  = addr_in[1] ? {rdata[15:0], 16'h0} : {16'h0, rdata[15:0]};
        first_be = addr_in[1] ? 4'b1100 : 4'b0011;
      end
      SZ_DBL: begin
        first_w  = big_end ? rdata[63:32] : rdata[31:0];
        second_w = big_end ? rdata[31:0]  : rdata[63:32];
        first_be = 4'b1111;
      end
      default: begin
        first_w  = rdata[31:0];
        first_be = 4'b1111;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
      mw_be    <= '0;
      hi_q     <= '0;
      dbl_q    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      undef_o  <= 1'b0;
    end else begin
      done    <= 1'b0;
      undef_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go_write) begin
            st       <= ST_B1;
            busy     <= 1'b1;
            mw_valid <= 1'b1;
            mw_addr  <= addr_in;
            mw_data  <= first_w;
            mw_be    <= first_be;
            hi_q     <= second_w;
            dbl_q    <= (size == SZ_DBL);
          end else if (go_skip) begin
            done    <= 1'b1;
            undef_o <= undef_in;
          end
        end
        ST_B1: begin
          if (mw_ready) begin
            if (dbl_q) begin
              st      <= ST_B2;
              mw_addr <= mw_addr + AW'(4);
              mw_data <= hi_q;
            end else begin
              st       <= ST_IDLE;
              mw_valid <= 1'b0;
              busy     <= 1'b0;
              done     <= 1'b1;
            end
          end
        end
        ST_B2: begin
          if (mw_ready) begin
            st       <= ST_IDLE;
            mw_valid <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data) && $stable(mw_be)));

  // R8
  second_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_B1 && dbl_q && mw_valid && mw_ready) |=> (mw_valid && mw_addr == $past(mw_addr) + AW'(4)));

  // R10
  valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mw_valid |-> busy);

  // R1
  undef_done_chk: assert property (@(posedge clk) disable iff (rst)
    undef_o |-> (done && !mw_valid));

  // R6
  be_shape_chk: assert property (@(posedge clk) disable iff (rst)
    mw_valid |-> (mw_be == 4'b1111 || mw_be == 4'b0011 || mw_be == 4'b1100));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/fpst_exec.sv
module fpst_exec
  import fpst_pkg::*;
#(
  parameter int AW             = 32,
  parameter int HALF_COND_MODE = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  input  logic [31:0]   instr_word,
  input  logic          cond_ok,
  input  logic          fp_on,
  input  logic          half_ok,
  input  logic          big_end,
  output logic [3:0]    base_idx,
  input  logic [AW-1:0] base_val,
  output logic [4:0]    rf_idx,
  output logic          rf_dbl,
  input  logic [63:0]   rf_rdata,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [31:0]   mw_data,
  output logic [3:0]    mw_be,
  output logic          busy,
  output logic          done,
  output logic          undef
);
  fpst_dec_t     dec;
  logic [AW-1:0] ea;
  logic          accept;
  logic          go_write;
  logic          go_skip;

  fpst_decode #(.HALF_COND_MODE(HALF_COND_MODE)) u_dec (
    .iw      (instr_word),
    .fp_on   (fp_on),
    .half_ok (half_ok),
    .dec     (dec)
  );

  fpst_agen #(.AW(AW)) u_agen (
    .base (base_val),
    .size (dec.size),
    .add  (dec.add),
    .imm  (dec.imm),
    .addr (ea)
  );

  always_comb begin
    base_idx = dec.bidx;
    rf_idx   = dec.ridx;
    rf_dbl   = (dec.size == SZ_DBL);
    accept   = instr_valid && !busy;
    go_write = accept && cond_ok && !dec.undef && !dec.nop;
    go_skip  = accept && !go_write;
  end

  fpst_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .go_write (go_write),
    .go_skip  (go_skip),
    .undef_in (dec.undef),
    .size     (dec.size),
    .addr_in  (ea),
    .rdata    (rf_rdata),
    .big_end  (big_end),
    .mw_ready (mw_ready),
    .mw_valid (mw_valid),
    .mw_addr  (mw_addr),
    .mw_data  (mw_data),
    .mw_be    (mw_be),
    .busy     (busy),
    .done     (done),
    .undef_o  (undef)
  );

  // R3
  skip_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (go_skip && !busy) |=> (done && !mw_valid));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    go_write |=> (busy && mw_valid));
endmodule

// File: tb/fpst_exec_tb_top.sv
`timescale 1ns/1ps
module fpst_exec_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          instr_valid = 1'b0;
  logic [31:0]   instr_word = '0;
  logic          cond_ok = 1'b1;
  logic          fp_on = 1'b1;
  logic          half_ok = 1'b1;
  logic          big_end = 1'b0;
  logic [3:0]    base_idx;
  logic [AW-1:0] base_val = '0;
  logic [4:0]    rf_idx;
  logic          rf_dbl;
  logic [63:0]   rf_rdata;
  logic          mw_valid;
  logic          mw_ready = 1'b0;
  logic [AW-1:0] mw_addr;
  logic [31:0]   mw_data;
  logic [3:0]    mw_be;
  logic          busy;
  logic          done;
  logic          undef;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] lo_of(input logic [4:0] i);
    return 32'h1357_9BDF ^ {4{3'b000, i}};
  endfunction
  function automatic logic [31:0] hi_of(input logic [4:0] i);
    return 32'h2468_ACE0 ^ {4{i, 3'b000}};
  endfunction

  assign rf_rdata = {hi_of(rf_idx), lo_of(rf_idx)};

  fpst_exec #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .cond_ok(cond_ok), .fp_on(fp_on), .half_ok(half_ok), .big_end(big_end),
    .base_idx(base_idx), .base_val(base_val), .rf_idx(rf_idx), .rf_dbl(rf_dbl),
    .rf_rdata(rf_rdata), .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_be(mw_be), .busy(busy), .done(done), .undef(undef)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] c, input logic u, input logic d,
                                     input logic [3:0] rn, input logic [3:0] vd,
                                     input logic [1:0] sz, input logic [7:0] imm);
    return {c, 4'b1101, u, d, 2'b00, rn, vd, 2'b10, sz, imm};
  endfunction

  // expected outcome
  logic          e_undef;
  int            e_nb;
  logic [AW-1:0] e_addr [2];
  logic [31:0]   e_data [2];
  logic [3:0]    e_be   [2];
  logic [4:0]    e_idx;

  task automatic predict(input logic [31:0] w, input logic [AW-1:0] b, input logic cok,
                         input logic fpon, input logic hok, input logic big);
    logic [1:0] sz = w[9:8];
    logic [AW-1:0] off;
    logic [AW-1:0] a;
    logic [31:0] lo, hi;
    logic legal_shape = (w[27:24] == 4'b1101) && (w[21:20] == 2'b00) && (w[11:10] == 2'b10);
    e_idx = (sz == 2'b11) ? {w[22], w[15:12]} : {w[15:12], w[22]};
    e_undef = !fpon || !legal_shape || (w[31:28] == 4'hF) || (sz == 2'b00) ||
              (sz == 2'b01 && (!hok || w[31:28] != 4'hE));
    off = (sz == 2'b01) ? AW'(w[7:0]) * 2 : AW'(w[7:0]) * 4;
    a = w[23] ? b + off : b - off;
    lo = lo_of(e_idx);
    hi = hi_of(e_idx);
    e_nb = 0;
    if (!e_undef && cok) begin
      e_addr[0] = a;
      e_addr[1] = a + 4;
      if (sz == 2'b01) begin
        e_nb = 1;
        e_data[0] = a[1] ? {lo[15:0], 16'h0} : {16'h0, lo[15:0]};
        e_be[0]   = a[1] ? 4'b1100 : 4'b0011;
      end else if (sz == 2'b10) begin
        e_nb = 1;
        e_data[0] = lo;
        e_be[0]   = 4'hF;
      end else begin
        e_nb = 2;
        e_data[0] = big ? hi : lo;
        e_data[1] = big ? lo : hi;
        e_be[0]   = 4'hF;
        e_be[1]   = 4'hF;
      end
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [AW-1:0] b, input logic cok,
                     input logic fpon, input logic hok, input logic big, input bit junk);
    int k = 0;
    bit got_done = 0;
    bit prev_stall = 0;
    string dreq;
    predict(w, b, cok, fpon, hok, big);
    dreq = (w[9:8] == 2'b01) ? "R6" : (w[9:8] == 2'b10) ? "R7" : "R8";
    @(negedge clk);
    chk(done == 1'b0, "R10 done pulse length", 64'(done), 64'd0);
    chk(busy == 1'b0, "R10 idle before issue", 64'(busy), 64'd0);
    instr_word = w; base_val = b; cond_ok = cok; fp_on = fpon; half_ok = hok; big_end = big;
    instr_valid = 1'b1;
    #1;
    chk(rf_idx == e_idx, "R5 register index", 64'(rf_idx), 64'(e_idx));
    chk(rf_dbl == (w[9:8] == 2'b11), "R5 double select", 64'(rf_dbl), 64'(w[9:8] == 2'b11));
    chk(base_idx == w[19:16], "R5 base index", 64'(base_idx), 64'(w[19:16]));
    @(negedge clk);
    instr_valid = 1'b0;
    for (int c = 0; c < 60 && !got_done; c++) begin
      if (mw_valid) begin
        if (k < e_nb) begin
          chk(mw_addr == e_addr[k], (k == 1) ? "R8 second address" : "R4 address",
              64'(mw_addr), 64'(e_addr[k]));
          chk(mw_data == e_data[k], dreq, 64'(mw_data), 64'(e_data[k]));
          chk(mw_be == e_be[k], dreq, 64'(mw_be), 64'(e_be[k]));
          if (prev_stall) chk(1'b1, "R9 held beat", 0, 0);
        end else begin
          chk(1'b0, e_undef ? "R1 unexpected write" : "R3 unexpected write", 64'(k), 64'(e_nb));
        end
        chk(busy == 1'b1, "R10 busy during write", 64'(busy), 64'd1);
      end
      if (done) begin
        got_done = 1;
        chk(undef == e_undef, e_undef ? "R1 undef flag" : "R3 undef flag", 64'(undef), 64'(e_undef));
        chk(k == e_nb, "R9 beat count", 64'(k), 64'(e_nb));
        chk(busy == 1'b0, "R10 busy after done", 64'(busy), 64'd0);
      end else begin
        if (junk && c == 0 && busy) begin
          instr_word = mk(4'hE, 1'b1, 1'b0, 4'h1, 4'h2, 2'b00, 8'h01);
          instr_valid = 1'b1;
        end
        mw_ready = ($urandom % 3) != 0;
        prev_stall = mw_valid && !mw_ready;
        if (mw_valid && mw_ready) k++;
        @(negedge clk);
        instr_valid = 1'b0;
        mw_ready = 1'b0;
      end
    end
    if (!got_done) chk(1'b0, "R10 done missing", 0, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mw_valid == 0 && busy == 0 && done == 0 && undef == 0, "R10 reset state",
        {60'd0, mw_valid, busy, done, undef}, 64'd0);

    // R1 size 00, NV condition, disabled unit, bad shape
    run(mk(4'hE, 1, 0, 4'h3, 4'h4, 2'b00, 8'h10), 32'h1000, 1, 1, 1, 0, 0);
    run(mk(4'hF, 1, 0, 4'h3, 4'h4, 2'b10, 8'h10), 32'h1000, 1, 1, 1, 0, 0);
    run(mk(4'hE, 1, 0, 4'h3, 4'h4, 2'b10, 8'h10), 32'h1000, 1, 0, 1, 0, 0);
    run(mk(4'hE, 1, 0, 4'h3, 4'h4, 2'b10, 8'h10) | 32'h0010_0000, 32'h1000, 1, 1, 1, 0, 0);
    run(mk(4'hE, 1, 0, 4'h3, 4'h4, 2'b10, 8'h10), 32'h1000, 0, 0, 1, 0, 0);
    // R2 half without support, half with non-always condition
    run(mk(4'hE, 1, 1, 4'h3, 4'h5, 2'b01, 8'h02), 32'h2000, 1, 1, 0, 0, 0);
    run(mk(4'h0, 1, 1, 4'h3, 4'h5, 2'b01, 8'h02), 32'h2000, 1, 1, 1, 0, 0);
    // R3 condition failed
    run(mk(4'h1, 1, 1, 4'h3, 4'h5, 2'b10, 8'h02), 32'h2000, 0, 1, 1, 0, 0);
    // R4 subtract with wrap, max immediate
    run(mk(4'hE, 0, 0, 4'h7, 4'h9, 2'b10, 8'hFF), 32'h0000_0010, 1, 1, 1, 0, 0);
    run(mk(4'hE, 1, 1, 4'h7, 4'hF, 2'b10, 8'hFF), 32'hFFFF_FF00, 1, 1, 1, 0, 0);
    // R6 half in both lanes
    run(mk(4'hE, 1, 1, 4'h2, 4'h6, 2'b01, 8'h01), 32'h3000, 1, 1, 1, 0, 0);
    run(mk(4'hE, 1, 0, 4'h2, 4'h6, 2'b01, 8'h02), 32'h3000, 1, 1, 1, 0, 0);
    // R8 double, both orders; R10 junk while busy
    run(mk(4'hE, 1, 1, 4'h5, 4'hA, 2'b11, 8'h04), 32'h4000, 1, 1, 1, 0, 1);
    run(mk(4'hE, 0, 1, 4'h5, 4'hA, 2'b11, 8'h04), 32'h4000, 1, 1, 1, 1, 1);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      logic [3:0] c = (($urandom % 6) == 0) ? 4'($urandom) : 4'hE;
      w = mk(c, 1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom),
             2'($urandom), 8'($urandom));
      if (($urandom % 16) == 0) w = w ^ (32'h1 << ($urandom % 32));
      run(w, 32'($urandom), ($urandom % 8) != 0, ($urandom % 16) != 0,
          ($urandom % 4) != 0, 1'($urandom), ($urandom % 4) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule